// File: doc/BRIEF.md
# Serial Port Data FIFO Path

This block is the data path of a synchronous serial port working as a bus master. Software sees one 16-bit data word. Writing that word queues it for transmission, and reading it takes the oldest received word. Two eight-entry queues separate the bus from the serial side. A frame engine takes queued words one at a time, shifts them out most significant bit first on a divided serial clock, and gathers the incoming bits into a right-justified word for the receive queue.

The frame length can be set from 4 to 16 bits. A command/response mode is also available. In that mode, each frame sends an 8-bit command and then receives a reply of the programmed length. Clearing the enable input stops new frames from starting but leaves both queues as they are. Software can therefore load transmit words before it starts the port.

Top module: `ser_port_core`

## Requirements
- R1: A cycle with `bus_wr` high appends `bus_wdata` to the transmit queue. `txq_empty` is high exactly when no words are queued, and `txq_full` is high exactly when 8 words are queued.
- R2: `bus_rdata` always shows the oldest received word. A cycle with `bus_rd` high removes that word, so the next word appears. `rxq_full` and `rxq_empty` report 8 stored words and 0 stored words.
- R3: In normal mode (`cmd_mode` low), a frame carries the low N bits of the queued word, most significant of those first. Bits above bit N-1 have no effect on `ser_out`.
- R4: The received N-bit value is stored right-justified in the receive queue with all upper bits zero. It is stored on the rising serial clock edge of the frame's last bit.
- R5: With `cmd_mode` high, a frame sends bits 7..0 of the word, then holds `ser_out` low for N further bits. Only those N bits of `ser_in` are received. Bits 15..8 of the written word are ignored.
- R6: Each queue holds 8 words. A write to a full transmit queue is dropped. A read of an empty receive queue returns 0 and changes nothing.
- R7: A frame starts only while `port_en` is high and the transmit queue is not empty. Clearing `port_en` lets the current frame finish and keeps all queued words. Words queued while the port is disabled are sent, in order, once it is enabled.
- R8: N is `size_code`+1 for codes 3..15. Codes 0..2 select N = 4.
- R9: `ser_clk` is low while idle. `ser_out` changes only on falling `ser_clk` edges or when a frame is loaded. `ser_in` is sampled on rising edges. `ser_sel_n` is low for the whole of every frame and high when idle.
- R10: One serial clock period is 2×(`rate_div`+1) system clock cycles. The first rising edge comes `rate_div`+1 cycles after a frame is loaded.
- R11: If the transmit queue is not empty when a frame ends, the next frame starts at once. `ser_sel_n` stays low and the serial clock keeps its period.
- R12: After reset both queues are empty and not full, `ser_sel_n` is 1, and `ser_clk`, `ser_out` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Allows new frames to start |
| size_code | input | 4 | Frame data length minus one |
| cmd_mode | input | 1 | Command/response framing: 8 bits out, then N bits in |
| rate_div | input | DIV_W (8) | Serial clock divider; half period is rate_div+1 cycles |
| bus_wr | input | 1 | Write strobe for the data word |
| bus_wdata | input | 16 | Word to queue for transmission |
| bus_rd | input | 1 | Read strobe; removes the oldest received word |
| bus_rdata | output | 16 | Oldest received word, or 0 when none is stored |
| txq_full | output | 1 | Transmit queue holds 8 words |
| txq_empty | output | 1 | Transmit queue holds no word |
| rxq_full | output | 1 | Receive queue holds 8 words |
| rxq_empty | output | 1 | Receive queue holds no word |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_sel_n | output | 1 | Frame select, active low |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
In normal mode the serial output is looped back to the input. Each word then appears twice: once as a bit stream and once as a received value. Words with busy upper bits are used to show that those bits are masked at both ends. Frame lengths of 16, 12, 8 and 4 bits (the last set by a code below 3) are run with several divider values. These runs distinguish an off-by-one in the length, the bit order or the clock period. Command mode is run with the input held high. This shows the 8-bit command phase, the zero fill on `ser_out` and the reply length as separate effects. A fill-while-disabled run and a disable-in-mid-frame run check queue capacity, the dropped ninth write, the read of an empty queue and the rule that enable only gates frame starts.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    localparam int WORD_W     = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int SIZE_W     = 4;
    localparam int LEN_W      = 5;
    localparam int CMD_BITS   = 8;
    localparam int MIN_LEN    = 4;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_t;

    typedef struct packed {
        logic             cmd;     // command/response framing latched at load
        logic [LEN_W-1:0] rx_len;  // received bits per frame
        logic [LEN_W-1:0] total;   // serial clock periods per frame
    } frame_cfg_t;

    function automatic logic [LEN_W-1:0] data_len(input logic [SIZE_W-1:0] code);
        if (code < SIZE_W'(MIN_LEN - 1))
            return LEN_W'(MIN_LEN);
        return {1'b0, code} + LEN_W'(1);
    endfunction

endpackage

// File: rtl/ser_sync_fifo.sv
module ser_sync_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R6: a push into a full queue without a pop leaves it full
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

    // R6: a pop from an empty queue without a push leaves it empty
    a_r6_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/ser_rate_div.sv
module ser_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R10: the half-period counter never passes the divider value while running
    a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(div)) |-> (cnt <= div));

endmodule

// File: rtl/ser_frame_engine.sv
module ser_frame_engine
    import ser_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              cmd_mode,
    input  logic              tick,
    output logic              running,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              sel_n,
    output logic              sdo,
    input  logic              sdi
);
    eng_state_t        st;
    frame_cfg_t        cfg, cfg_n;
    logic [WORD_W-1:0] tx_sh, rx_sh, tx_load;
    logic [LEN_W-1:0]  idx;
    logic              start, last, rx_phase, rise, fall;

    // configuration and shifter image for the next frame
    always_comb begin
        cfg_n.cmd    = cmd_mode;
        cfg_n.rx_len = data_len(size_code);
        cfg_n.total  = cmd_mode ? cfg_n.rx_len + LEN_W'(CMD_BITS) : cfg_n.rx_len;
        if (cmd_mode)
            tx_load = {tx_word[CMD_BITS-1:0], {(WORD_W-CMD_BITS){1'b0}}};
        else
            tx_load = tx_word << (LEN_W'(WORD_W) - cfg_n.rx_len);
    end

    assign running  = (st == ENG_RUN);
    assign start    = en && !tx_empty;
    assign last     = (idx == cfg.total - LEN_W'(1));
    assign rx_phase = !cfg.cmd || (idx >= LEN_W'(CMD_BITS));
    assign rise     = running && tick && !sclk;
    assign fall     = running && tick && sclk;
    assign tx_pop   = (!running && start) || (fall && last && start);
    assign rx_push  = rise && last;
    assign rx_word  = {rx_sh[WORD_W-2:0], sdi};
    assign sdo      = running && tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ENG_IDLE;
            cfg   <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            idx   <= '0;
            sclk  <= 1'b0;
            sel_n <= 1'b1;
        end else if (!running) begin
            if (start) begin
                st    <= ENG_RUN;
                sel_n <= 1'b0;
                cfg   <= cfg_n;
                tx_sh <= tx_load;
                rx_sh <= '0;
                idx   <= '0;
            end
        end else if (rise) begin
            sclk <= 1'b1;
            if (rx_phase)
                rx_sh <= rx_word;
        end else if (fall) begin
            sclk <= 1'b0;
            if (!last) begin
                tx_sh <= tx_sh << 1;
                idx   <= idx + LEN_W'(1);
            end else if (start) begin
                cfg   <= cfg_n;
                tx_sh <= tx_load;
                rx_sh <= '0;
                idx   <= '0;
            end else begin
                st    <= ENG_IDLE;
                sel_n <= 1'b1;
                idx   <= '0;
            end
        end
    end

    // R9: the serial clock is only high inside a selected frame
    a_r9_clk_in_frame: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !sel_n);

    // R10: the serial clock moves only on divider ticks
    a_r10_clk_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sclk));

    // R7: no frame begins while the port is disabled
    a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en && !running) |=> !running);

    // R5: the output is held low during the reply phase
    a_r5_reply_low: assert property (@(posedge clk) disable iff (rst)
        (running && cfg.cmd && idx >= LEN_W'(CMD_BITS)) |-> !sdo);

    // R4: a received word is stored only on a rising edge inside a frame
    a_r4_push_on_rise: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (!sel_n && !sclk));

endmodule

// File: rtl/ser_port_core.sv
module ser_port_core
    import ser_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              cmd_mode,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              txq_full,
    output logic              txq_empty,
    output logic              rxq_full,
    output logic              rxq_empty,
    output logic              ser_clk,
    output logic              ser_sel_n,
    output logic              ser_out,
    input  logic              ser_in
);
    logic [WORD_W-1:0] tx_head, rx_word;
    logic              tx_pop, rx_push, running, tick;

    ser_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (bus_wr),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (txq_full),
        .empty (txq_empty)
    );

    ser_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (bus_rd),
        .rdata (bus_rdata),
        .full  (rxq_full),
        .empty (rxq_empty)
    );

    ser_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .div  (rate_div),
        .tick (tick)
    );

    ser_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (port_en),
        .size_code (size_code),
        .cmd_mode  (cmd_mode),
        .tick      (tick),
        .running   (running),
        .tx_empty  (txq_empty),
        .tx_word   (tx_head),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .sclk      (ser_clk),
        .sel_n     (ser_sel_n),
        .sdo       (ser_out),
        .sdi       (ser_in)
    );

    // R1: a word is taken for transmission only when one is queued
    a_r1_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !txq_empty);

endmodule

// File: tb/sim_ser_port_core.sv
`timescale 1ns/1ps
module sim_ser_port_core;

    localparam real CLK_NS = 5.0;

    typedef struct packed {
        logic [23:0] bits;
        logic [5:0]  total;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [3:0]  size_code = 4'd15;
    logic        cmd_mode = 1'b0;
    logic [7:0]  rate_div = 8'd1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        txq_full, txq_empty, rxq_full, rxq_empty;
    logic        ser_clk, ser_sel_n, ser_out, ser_in;
    logic        loopback = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    frame_t      txq_exp[$];
    logic [15:0] rxq_exp[$];

    always #2.5 clk = ~clk;

    assign ser_in = loopback ? ser_out : 1'b1;

    ser_port_core u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .size_code(size_code),
        .cmd_mode(cmd_mode), .rate_div(rate_div), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .txq_full(txq_full), .txq_empty(txq_empty), .rxq_full(rxq_full),
        .rxq_empty(rxq_empty), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_out(ser_out), .ser_in(ser_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_len();
        return (size_code < 4'd3) ? 4 : int'(size_code) + 1;
    endfunction

    // driver: writes a word and records what the monitor and the reads should see
    task automatic push_word(input logic [15:0] v, input bit accepted);
        int          n;
        logic [15:0] mask;
        frame_t      f;
        n    = eff_len();
        mask = 16'((32'd1 << n) - 1);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (accepted) begin
            if (cmd_mode) begin
                f.bits  = 24'(v[7:0]) << n;
                f.total = 6'(8 + n);
                rxq_exp.push_back(mask);
            end else begin
                f.bits  = 24'(v & mask);
                f.total = 6'(n);
                rxq_exp.push_back(v & mask);
            end
            txq_exp.push_back(f);
        end
    endtask

    task automatic read_word(input string req);
        logic [15:0] e;
        e = (rxq_exp.size() != 0) ? rxq_exp.pop_front() : 16'h0;
        @(negedge clk);
        check(bus_rdata === e, req, 32'(bus_rdata), 32'(e));
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done();
        while (txq_exp.size() != 0 || ser_sel_n !== 1'b1)
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: collects serial bits per frame and compares with the driver's queue
    int          bitcnt = 0;
    logic [23:0] cap = '0;
    frame_t      cur;
    realtime     prev_rise = 0.0;
    realtime     t_chg = 0.0;

    always @(ser_out) t_chg = $realtime;
    always @(posedge ser_sel_n) prev_rise = 0.0;

    always @(posedge ser_clk) begin
        realtime half;
        half = (real'(rate_div) + 1.0) * CLK_NS;
        check(ser_sel_n === 1'b0, "R9 select low during frame", 32'(ser_sel_n), 32'h0);
        check($realtime - t_chg >= half - 0.1, "R9 data stable before rising edge",
              32'(int'($realtime - t_chg)), 32'(int'(half)));
        if (prev_rise != 0.0) begin
            realtime d;
            d = $realtime - prev_rise;
            if (bitcnt == 0)
                check(d > 2.0*half - 0.1 && d < 2.0*half + 0.1, "R11 no gap between frames",
                      32'(int'(d)), 32'(int'(2.0*half)));
            else
                check(d > 2.0*half - 0.1 && d < 2.0*half + 0.1, "R10 serial clock period",
                      32'(int'(d)), 32'(int'(2.0*half)));
        end
        prev_rise = $realtime;
        if (bitcnt == 0) begin
            if (txq_exp.size() == 0) begin
                check(1'b0, "R7 unexpected frame", 32'h1, 32'h0);
                cur.total = 6'd1;
                cur.bits  = '0;
            end else begin
                cur = txq_exp[0];
            end
            cap = '0;
        end
        cap = {cap[22:0], ser_out};
        bitcnt++;
        if (bitcnt == int'(cur.total)) begin
            check(cap == cur.bits, "R3/R5 serial frame bits", 32'(cap), 32'(cur.bits));
            if (txq_exp.size() != 0) void'(txq_exp.pop_front());
            bitcnt = 0;
        end
    end

    initial begin
        #(200000 * CLK_NS);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(txq_empty === 1'b1 && txq_full === 1'b0, "R12 tx flags", {txq_full, txq_empty}, 32'h1);
        check(rxq_empty === 1'b1 && rxq_full === 1'b0, "R12 rx flags", {rxq_full, rxq_empty}, 32'h1);
        check(ser_sel_n === 1'b1 && ser_clk === 1'b0 && ser_out === 1'b0, "R12 serial idle",
              {ser_sel_n, ser_clk, ser_out}, 32'h4);
        check(bus_rdata === 16'h0, "R12 read data", 32'(bus_rdata), 32'h0);

        // R7/R6/R1: fill while disabled, ninth write dropped
        size_code = 4'd15; rate_div = 8'd1; loopback = 1'b1;
        for (int i = 0; i < 8; i++) begin
            push_word(16'h1111 * 16'(i + 1) ^ 16'h8421, 1'b1);
            check(txq_empty === 1'b0, "R1 queue not empty after write", 32'(txq_empty), 32'h0);
        end
        check(txq_full === 1'b1, "R6 full at eight words", 32'(txq_full), 32'h1);
        push_word(16'hDEAD, 1'b0);
        repeat (40) @(negedge clk);
        check(ser_sel_n === 1'b1, "R7 no frame while disabled", 32'(ser_sel_n), 32'h1);
        port_en = 1'b1;
        wait_done();
        check(txq_empty === 1'b1, "R7 preloaded words sent", 32'(txq_empty), 32'h1);
        check(rxq_full === 1'b1, "R6 receive queue full at eight", 32'(rxq_full), 32'h1);
        for (int i = 0; i < 8; i++) read_word("R2/R4 16-bit loopback read");
        check(rxq_empty === 1'b1, "R2 empty after reads", 32'(rxq_empty), 32'h1);
        read_word("R6 empty read returns zero");
        check(rxq_empty === 1'b1 && bus_rdata === 16'h0, "R6 empty read no effect",
              32'(bus_rdata), 32'h0);

        // R3/R4: 8-bit frames, upper bits masked, fastest divider
        size_code = 4'd7; rate_div = 8'd0;
        push_word(16'hABCD, 1'b1);
        push_word(16'h1234, 1'b1);
        push_word(16'hFF5A, 1'b1);
        wait_done();
        for (int i = 0; i < 3; i++) read_word("R3/R4 8-bit masked read");

        // R3/R10: 12-bit frames, slower divider
        size_code = 4'd11; rate_div = 8'd3;
        push_word(16'hF9E7, 1'b1);
        push_word(16'h0801, 1'b1);
        wait_done();
        for (int i = 0; i < 2; i++) read_word("R4 12-bit read");

        // R8: code below 3 gives 4-bit frames
        size_code = 4'd1; rate_div = 8'd2;
        push_word(16'hFFF6, 1'b1);
        push_word(16'h0009, 1'b1);
        wait_done();
        for (int i = 0; i < 2; i++) read_word("R8 4-bit read");

        // R5: command/response mode, 10-bit reply with input held high
        cmd_mode = 1'b1; loopback = 1'b0; size_code = 4'd9; rate_div = 8'd1;
        push_word(16'hA5C3, 1'b1);
        push_word(16'h7E81, 1'b1);
        wait_done();
        for (int i = 0; i < 2; i++) read_word("R5 reply right-justified");
        cmd_mode = 1'b0; loopback = 1'b1;

        // R7: disable during a frame; it finishes, the next waits
        size_code = 4'd15; rate_div = 8'd3;
        push_word(16'h3C5A, 1'b1);
        push_word(16'hC3A5, 1'b1);
        @(negedge clk);
        port_en = 1'b0;
        while (ser_sel_n !== 1'b1) @(negedge clk);
        check(txq_exp.size() == 1, "R7 current frame completed", 32'(txq_exp.size()), 32'h1);
        check(txq_empty === 1'b0, "R7 queued word kept", 32'(txq_empty), 32'h0);
        repeat (40) @(negedge clk);
        check(ser_sel_n === 1'b1, "R7 stays idle while disabled", 32'(ser_sel_n), 32'h1);
        port_en = 1'b1;
        wait_done();
        for (int i = 0; i < 2; i++) read_word("R7 words after re-enable");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule